// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Registered Status

This block is the datapath arithmetic and logic unit for a small accumulator-style processor. Each cycle it takes the accumulator value, an operand byte and an operation code, and it produces a result byte straight away through combinational logic. A status byte holds carry, zero, interrupt-disable, decimal, overflow and negative flags. The arithmetic and rotate operations read their carry input from this register.

When `valid_i` is high, the flags produced by the selected operation are written into the status byte at the next rising edge. A separate load path writes a whole byte into the status register, for example a value pulled from the stack. Every loaded value has bits 4 and 5 forced to zero.

Decimal arithmetic, instruction decode and memory sequencing are handled elsewhere. The decimal flag is stored, but it has no effect on any operation in this block.

Top module: `alu8_core`

## Requirements
- R1: Add (op code 0) gives res_o = (acc + opnd + C)[7:0], where C is status bit 0. After the edge, C is set exactly when the 9-bit sum exceeds 0xFF. Z (bit 1) is set when the result is zero, and N (bit 7) equals result bit 7.
- R2: For add and subtract, overflow V (status bit 6) is set when the two adder inputs have the same sign bit and the result's sign bit differs from it.
- R3: Subtract (op code 1) is the add of R1 applied to opnd XOR 0xFF, with C used as not-borrow. After a subtract, C = 1 means no borrow occurred.
- R4: Compare (op code 2) drives res_o = acc. It sets C when acc >= opnd (unsigned) and Z when acc == opnd. N takes bit 7 of (acc - opnd). V is unchanged.
- R5: AND, OR and XOR (op codes 3, 4, 5) produce the bitwise result. Z and N follow that result, and C and V are unchanged.
- R6: Bit test (op code 6) drives res_o = acc. It sets Z when (acc & opnd) == 0, copies V from opnd bit 6 and N from opnd bit 7, and leaves C unchanged.
- R7: The shifts and rotates act on acc only. Shift left (7) and rotate left (9) take C from acc bit 7. Shift right (8) and rotate right (10) take C from acc bit 0. The shifts fill the vacated bit with 0, and the rotates fill it with the old C. Z and N follow the result, and V is unchanged.
- R8: AND-then-rotate (op code 11) gives res_o = ((acc & opnd) >> 1) with the old C placed in bit 7. The new C is result bit 6, V is result bit 6 XOR result bit 5, and Z and N follow the result.
- R9: When ld_i is high, status_o becomes ld_val_i & 0xCF at the next edge. The load takes priority over valid_i. Status bits 5 and 4 always read 0.
- R10: The status byte changes only at an edge where valid_i or ld_i is high. Op codes 12 to 15 drive res_o = acc and leave the status unchanged. The decimal flag (bit 3) and the interrupt flag (bit 2) are held, and they do not alter any result or flag.
- R11: While rst_n is low, status_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the status byte |
| valid_i | input | 1 | Commit the flags of op_i at the next edge |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Operand byte |
| ld_i | input | 1 | Load the status byte from ld_val_i |
| ld_val_i | input | 8 | Status value to load, masked with 0xCF |
| res_o | output | 8 | Combinational result |
| status_o | output | 8 | Registered status byte: C0 Z1 I2 D3 V6 N7 |

## Verification
The result `res_o` is combinational. It is due in the same cycle as its inputs, and it already reflects the carry held in the status register during that cycle. The flags of an operation, or a loaded status value, appear on `status_o` one edge later. The driver applies stimulus on the falling edge and queues one expected item per cycle. The monitor compares `res_o` one nanosecond after that falling edge, before the next rising edge, and compares `status_o` one nanosecond after the rising edge. In this way each result and each status value is checked in the cycle it becomes due, and the carry chain from one operation to the next is followed across consecutive items.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_CMP    = 4'd2,
        OP_AND    = 4'd3,
        OP_OR     = 4'd4,
        OP_XOR    = 4'd5,
        OP_TST    = 4'd6,
        OP_SHL    = 4'd7,
        OP_SHR    = 4'd8,
        OP_ROLC   = 4'd9,
        OP_RORC   = 4'd10,
        OP_ANDROR = 4'd11,
        OP_PASS   = 4'd12
    } op_e;

    localparam int unsigned ST_W  = 8;
    localparam int unsigned FL_C  = 0;
    localparam int unsigned FL_Z  = 1;
    localparam int unsigned FL_I  = 2;
    localparam int unsigned FL_D  = 3;
    localparam int unsigned FL_V  = 6;
    localparam int unsigned FL_N  = 7;
    localparam logic [ST_W-1:0] ST_LOAD_MASK = 8'hCF;

    // Flag values plus per-flag write enables produced by one unit
    typedef struct packed {
        logic c;
        logic v;
        logic z;
        logic n;
        logic wr_c;
        logic wr_v;
        logic wr_z;
        logic wr_n;
    } flag_upd_t;

    typedef struct packed {
        logic [ST_W-1:0] status;
    } alu_state_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  op_e            sel_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   m_i,
    input  logic           cin_i,
    output logic [W-1:0]   res_o,
    output flag_upd_t      fl_o
);
    logic [W-1:0] m_eff;
    logic [W:0]   sum;
    logic [W:0]   diff;
    logic         is_cmp;

    always_comb begin
        is_cmp = (sel_i == OP_CMP);
        m_eff  = (sel_i == OP_SUB) ? ~m_i : m_i;
        sum    = {1'b0, a_i} + {1'b0, m_eff} + {{W{1'b0}}, cin_i};
        diff   = {1'b0, a_i} - {1'b0, m_i};
        fl_o   = '0;
        if (is_cmp) begin
            res_o     = a_i;
            fl_o.c    = ~diff[W];
            fl_o.z    = (diff[W-1:0] == '0);
            fl_o.n    = diff[W-1];
            fl_o.wr_c = 1'b1;
            fl_o.wr_z = 1'b1;
            fl_o.wr_n = 1'b1;
        end else begin
            res_o     = sum[W-1:0];
            fl_o.c    = sum[W];
            fl_o.v    = ~(a_i[W-1] ^ m_eff[W-1]) & (a_i[W-1] ^ sum[W-1]);
            fl_o.z    = (sum[W-1:0] == '0);
            fl_o.n    = sum[W-1];
            fl_o.wr_c = 1'b1;
            fl_o.wr_v = 1'b1;
            fl_o.wr_z = 1'b1;
            fl_o.wr_n = 1'b1;
        end
    end

    // R4: equal operands must give carry and zero together
    always_comb begin
        if (is_cmp && (a_i == m_i)) begin
            p_cmp_eq_r4: assert (fl_o.c && fl_o.z && !fl_o.wr_v);
        end
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  op_e            sel_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   m_i,
    output logic [W-1:0]   res_o,
    output flag_upd_t      fl_o
);
    logic [W-1:0] conj;

    always_comb begin
        conj = a_i & m_i;
        fl_o = '0;
        unique case (sel_i)
            OP_AND:  res_o = conj;
            OP_OR:   res_o = a_i | m_i;
            OP_XOR:  res_o = a_i ^ m_i;
            default: res_o = a_i;
        endcase
        if (sel_i == OP_TST) begin
            fl_o.z    = (conj == '0);
            fl_o.v    = m_i[W-2];
            fl_o.n    = m_i[W-1];
            fl_o.wr_z = 1'b1;
            fl_o.wr_v = 1'b1;
            fl_o.wr_n = 1'b1;
        end else begin
            fl_o.z    = (res_o == '0);
            fl_o.n    = res_o[W-1];
            fl_o.wr_z = 1'b1;
            fl_o.wr_n = 1'b1;
        end
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  op_e            sel_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   m_i,
    input  logic           cin_i,
    output logic [W-1:0]   res_o,
    output flag_upd_t      fl_o
);
    logic [W-1:0] masked;
    logic         fill;
    logic         left;

    always_comb begin
        masked = a_i & m_i;
        left   = (sel_i == OP_SHL) || (sel_i == OP_ROLC);
        fill   = ((sel_i == OP_ROLC) || (sel_i == OP_RORC)) ? cin_i : 1'b0;
        fl_o   = '0;
        if (sel_i == OP_ANDROR) begin
            res_o     = {cin_i, masked[W-1:1]};
            fl_o.c    = res_o[W-2];
            fl_o.v    = res_o[W-2] ^ res_o[W-3];
            fl_o.wr_v = 1'b1;
        end else if (left) begin
            res_o  = {a_i[W-2:0], fill};
            fl_o.c = a_i[W-1];
        end else begin
            res_o  = {fill, a_i[W-1:1]};
            fl_o.c = a_i[0];
        end
        fl_o.z    = (res_o == '0);
        fl_o.n    = res_o[W-1];
        fl_o.wr_c = 1'b1;
        fl_o.wr_z = 1'b1;
        fl_o.wr_n = 1'b1;
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [3:0]      op_i,
    input  logic [W-1:0]    acc_i,
    input  logic [W-1:0]    opnd_i,
    input  logic            ld_i,
    input  logic [ST_W-1:0] ld_val_i,
    output logic [W-1:0]    res_o,
    output logic [ST_W-1:0] status_o
);
    typedef enum logic [1:0] { U_ARITH, U_LOGIC, U_SHIFT, U_NONE } unit_e;

    op_e        op;
    unit_e      unit;
    alu_state_t st_d, st_q;
    logic       cin;

    logic [W-1:0] res_ar, res_lg, res_sh;
    flag_upd_t    fl_ar, fl_lg, fl_sh, fl_sel;

    assign op  = op_e'(op_i);
    assign cin = st_q.status[FL_C];

    alu8_arith #(.W(W)) u_arith (
        .sel_i(op), .a_i(acc_i), .m_i(opnd_i), .cin_i(cin),
        .res_o(res_ar), .fl_o(fl_ar)
    );

    alu8_logic #(.W(W)) u_logic (
        .sel_i(op), .a_i(acc_i), .m_i(opnd_i),
        .res_o(res_lg), .fl_o(fl_lg)
    );

    alu8_shift #(.W(W)) u_shift (
        .sel_i(op), .a_i(acc_i), .m_i(opnd_i), .cin_i(cin),
        .res_o(res_sh), .fl_o(fl_sh)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB, OP_CMP:             unit = U_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_TST:      unit = U_LOGIC;
            OP_SHL, OP_SHR, OP_ROLC, OP_RORC,
            OP_ANDROR:                          unit = U_SHIFT;
            default:                            unit = U_NONE;
        endcase

        unique case (unit)
            U_ARITH: begin res_o = res_ar; fl_sel = fl_ar; end
            U_LOGIC: begin res_o = res_lg; fl_sel = fl_lg; end
            U_SHIFT: begin res_o = res_sh; fl_sel = fl_sh; end
            default: begin res_o = acc_i;  fl_sel = '0;    end
        endcase

        st_d = st_q;
        if (ld_i) begin
            st_d.status = ld_val_i & ST_LOAD_MASK;
        end else if (valid_i) begin
            if (fl_sel.wr_c) st_d.status[FL_C] = fl_sel.c;
            if (fl_sel.wr_v) st_d.status[FL_V] = fl_sel.v;
            if (fl_sel.wr_z) st_d.status[FL_Z] = fl_sel.z;
            if (fl_sel.wr_n) st_d.status[FL_N] = fl_sel.n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;

    // R10: status held when nothing commits
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !ld_i) |=> $stable(status_o));

    // R9: loaded value arrives masked one edge later
    p_load_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (status_o == ($past(ld_val_i) & ST_LOAD_MASK)));

    // R9: bits 5 and 4 never set
    p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[5:4] == 2'b00);

    // R5: logic ops keep carry and overflow
    p_logic_cv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !ld_i && (op_i inside {4'd3, 4'd4, 4'd5}))
        |=> (status_o[FL_C] == $past(status_o[FL_C]))
         && (status_o[FL_V] == $past(status_o[FL_V])));

    // R4: compare leaves the register value on the result
    p_cmp_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd2) |-> (res_o == acc_i));

    // R10: decimal and interrupt bits held across operations
    p_di_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !ld_i) |=> (status_o[FL_D] == $past(status_o[FL_D]))
                            && (status_o[FL_I] == $past(status_o[FL_I])));

endmodule

// File: tb/sim_alu8_core.sv
`timescale 1ns/100ps
module sim_alu8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic       ld_i = 1'b0;
    logic [7:0] ld_val_i = '0;
    logic [7:0] res_o;
    logic [7:0] status_o;

    always #2.5 clk = ~clk;

    alu8_core u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .acc_i(acc_i), .opnd_i(opnd_i), .ld_i(ld_i), .ld_val_i(ld_val_i),
        .res_o(res_o), .status_o(status_o)
    );

    typedef struct {
        logic       chk_res;
        logic [7:0] res;
        logic [7:0] st;
        string      tag;
    } item_t;

    item_t      q[$];
    int         n_tests = 0;
    int         n_fail  = 0;
    logic [7:0] exp_st  = 8'h00;
    bit         done    = 1'b0;

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0:                 return "R1/R2";
            4'd1:                 return "R3/R2";
            4'd2:                 return "R4";
            4'd3, 4'd4, 4'd5:     return "R5";
            4'd6:                 return "R6";
            4'd7, 4'd8, 4'd9,
            4'd10:                return "R7";
            4'd11:                return "R8";
            default:              return "R10";
        endcase
    endfunction

    // Expected result and next status, from the requirement text
    task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                         input logic [7:0] st, output logic [7:0] r, output logic [7:0] ns);
        logic [8:0] s;
        logic [7:0] mi;
        logic       c;
        logic [7:0] t;
        c  = st[0];
        ns = st;
        r  = a;
        case (op)
            4'd0, 4'd1: begin
                mi = (op == 4'd1) ? (m ^ 8'hFF) : m;
                s  = 9'(a) + 9'(mi) + 9'(c);
                r  = s[7:0];
                ns[0] = s[8];
                ns[6] = (a[7] == mi[7]) && (r[7] != a[7]);
                ns[1] = (r == 8'h00);
                ns[7] = r[7];
            end
            4'd2: begin
                t = a - m;
                ns[0] = (a >= m);
                ns[1] = (a == m);
                ns[7] = t[7];
            end
            4'd3, 4'd4, 4'd5: begin
                r = (op == 4'd3) ? (a & m) : (op == 4'd4) ? (a | m) : (a ^ m);
                ns[1] = (r == 8'h00);
                ns[7] = r[7];
            end
            4'd6: begin
                ns[1] = ((a & m) == 8'h00);
                ns[6] = m[6];
                ns[7] = m[7];
            end
            4'd7, 4'd8, 4'd9, 4'd10, 4'd11: begin
                case (op)
                    4'd7:    begin r = a << 1;          ns[0] = a[7]; end
                    4'd8:    begin r = a >> 1;          ns[0] = a[0]; end
                    4'd9:    begin r = {a[6:0], c};     ns[0] = a[7]; end
                    4'd10:   begin r = {c, a[7:1]};     ns[0] = a[0]; end
                    default: begin
                        t = a & m;
                        r = {c, t[7:1]};
                        ns[0] = r[6];
                        ns[6] = r[6] ^ r[5];
                    end
                endcase
                ns[1] = (r == 8'h00);
                ns[7] = r[7];
            end
            default: ;
        endcase
    endtask

    task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                         input logic v, input logic ld, input logic [7:0] ldv);
        item_t      it;
        logic [7:0] r, ns;
        @(negedge clk);
        op_i = op; acc_i = a; opnd_i = m; valid_i = v; ld_i = ld; ld_val_i = ldv;
        model(op, a, m, exp_st, r, ns);
        it.chk_res = 1'b1;
        it.res     = r;
        if (ld) begin
            it.st  = ldv & 8'hCF;
            it.tag = "R9";
        end else if (v) begin
            it.st  = ns;
            it.tag = tag_of(op);
        end else begin
            it.st  = exp_st;
            it.tag = "R10";
        end
        exp_st = it.st;
        q.push_back(it);
    endtask

    task automatic load(input logic [7:0] val);
        drive(4'd15, 8'h00, 8'h00, 1'b0, 1'b1, val);
    endtask

    // Monitor: result before the rising edge, status just after it
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                it = q.pop_front();
                if (it.chk_res) begin
                    n_tests++;
                    if (res_o !== it.res) begin
                        n_fail++;
                        $display("FAIL %s result: actual %02h expected %02h", it.tag, res_o, it.res);
                    end
                end
                @(posedge clk);
                #1;
                n_tests++;
                if (status_o !== it.st) begin
                    n_fail++;
                    $display("FAIL %s status: actual %02h expected %02h", it.tag, status_o, it.st);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    localparam int NPAT = 9;
    logic [7:0] pa [NPAT] = '{8'h50, 8'hFF, 8'h80, 8'h00, 8'h7F, 8'h40, 8'h3C, 8'h01, 8'hD0};
    logic [7:0] pm [NPAT] = '{8'h50, 8'h01, 8'h80, 8'h00, 8'h01, 8'hC0, 8'h3C, 8'h02, 8'h90};

    initial begin
        #12;
        // R11: reset value
        n_tests++;
        if (status_o !== 8'h00) begin
            n_fail++;
            $display("FAIL R11 reset status: actual %02h expected 00", status_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R2 directed: 0x50+0x50 gives 0xA0 with V and N
        drive(4'd0, 8'h50, 8'h50, 1'b1, 1'b0, 8'h00);
        // R3 directed: 0x05-0x03 with C=1 (from load) gives 0x02, C=1
        load(8'h01);
        drive(4'd1, 8'h05, 8'h03, 1'b1, 1'b0, 8'h00);
        // R9: 0xFF load masked to 0xCF
        load(8'hFF);
        // R9: load wins over a valid operation in the same cycle
        drive(4'd0, 8'h01, 8'h01, 1'b1, 1'b1, 8'h30);

        // Sweep every op code over patterns, with carry clear and set
        for (int cset = 0; cset < 2; cset++) begin
            for (int op = 0; op < 16; op++) begin
                for (int p = 0; p < NPAT; p++) begin
                    load(cset ? 8'h41 : 8'h80);
                    drive(4'(op), pa[p], pm[p], 1'b1, 1'b0, 8'h00);
                    // R10: idle cycle with the same inputs leaves status alone
                    drive(4'(op), pm[p], pa[p], 1'b0, 1'b0, 8'h00);
                end
            end
        end

        // R10: decimal flag set does not change add/sub results
        load(8'h08);
        drive(4'd0, 8'h19, 8'h28, 1'b1, 1'b0, 8'h00);
        drive(4'd1, 8'h10, 8'h01, 1'b1, 1'b0, 8'h00);
        load(8'h0D);
        drive(4'd9, 8'h80, 8'h00, 1'b1, 1'b0, 8'h00);
        drive(4'd11, 8'hFF, 8'hFF, 1'b1, 1'b0, 8'h00);

        // Chains: carry flows between consecutive ops (R1, R7)
        load(8'h00);
        drive(4'd0, 8'hFF, 8'h01, 1'b1, 1'b0, 8'h00);
        drive(4'd0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00);
        drive(4'd10, 8'h02, 8'h00, 1'b1, 1'b0, 8'h00);
        drive(4'd2, 8'h10, 8'h20, 1'b1, 1'b0, 8'h00);

        drive(4'd15, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule